// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block puts a bank of general-purpose I/O lines behind a small memory-mapped register port. One register holds the output latch and another holds the direction mask. Software drives lines through set and clear registers and sets their direction through either of two registers of opposite polarity. It reads the synchronised pin levels through a data register. Each line drives a tri-state pad through an output enable and an output value, and it returns the pad level on an input.

The bus moves one register per access. The register width is a parameter of 8, 16, 32 or 64 bits, and the number of lines equals that width. Four options are fixed at elaboration. Line numbering can be mirrored. Bus byte lanes can be reversed. The clear register can be omitted, in which case the set register loads the whole latch. The depth of the pad synchroniser is also a parameter.

Top module: `mmgpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset the output latch is zero and every line is an input, so `pad_out` and `pad_oe` are all zeros.
- R2: A read strobe (`bus_sel`=1, `bus_we`=0) at a clock edge places the addressed register on `bus_rdata` at that edge. Offsets are 0 data, 1 set, 2 clear, 3 direction-out and 4 direction-in. Offsets 5 to 7 read zero, the clear offset reads zero, and writes to offsets 5 to 7 change nothing.
- R3: With the clear register present, a write to offset 1 raises every line whose bit is 1 and leaves the other lines alone. A read of offset 1 returns the output latch.
- R4: With the clear register present, a write to offset 2 lowers every line whose bit is 1 and leaves the other lines alone.
- R5: With the clear register absent, a write to offset 1 loads the whole latch, so 0 bits drive lines low, and writes to offset 2 are ignored.
- R6: In the direction-out register (offset 3) a 1 makes a line an output (`pad_oe`=1). The register reads back the direction mask.
- R7: In the direction-in register (offset 4) a 1 makes a line an input. It always reads as the bitwise complement of the direction-out register.
- R8: Offset 0 returns the pad levels after a two-stage synchroniser. A level applied to `pad_in` is not seen by a read strobe at the next edge. It is seen by a read strobe at the third edge after it is applied. Writes to offset 0 change nothing.
- R9: With mirrored numbering, line n corresponds to register bit (width-1-n).
- R10: With lane reversal, register byte k appears in bus byte (bytes-1-k) for 16- and 32-bit widths. The 64-bit width refuses this option at elaboration.
- R11: A line set as an output reads back its own driven value through offset 0 once the synchroniser latency has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register offset in register units |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, registered |
| pad_in | input | REG_W | Level seen at each pad |
| pad_out | output | REG_W | Value driven by each pad |
| pad_oe | output | REG_W | Output enable of each pad |

## Verification
A corrupted latch shows on `pad_out` on the edge after the faulty write. A corrupted direction mask shows on `pad_oe` just as fast. A wrong read path or lane map shows only when the register is read back, one edge after the strobe, so every write is followed by a read of the affected register. A synchroniser with the wrong depth shows as a data read that arrives one cycle early or late around a pin change. The bench therefore reads at both sides of the expected latency.

// File: rtl/mmgpio_pkg.sv
// Shared offsets for the GPIO register controller.
// Assumes a register-unit address of at least three bits.
package mmgpio_pkg;
    localparam int unsigned OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_SET  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CLR  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_DOUT = 3'd3;
    localparam logic [OFS_W-1:0] OFS_DIN  = 3'd4;
endpackage

// File: rtl/mmgpio_sync.sv
// Multi-stage synchroniser for the pad inputs.
// Assumes STAGES >= 1. Every flop clears on reset.
module mmgpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // shift one stage of the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= async_i;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/mmgpio_lane_map.sv
// Maps between bus words and line vectors. It applies optional mirrored
// numbering and optional byte-lane reversal. Both maps undo themselves,
// so the same index serves both directions. Pure wiring.
module mmgpio_lane_map #(
    parameter int unsigned W      = 32,
    parameter bit          MIRROR = 1'b0,
    parameter bit          BSWAP  = 1'b0
) (
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] line_o,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] bus_o
);
    localparam int unsigned NBYTES = W / 8;

    generate
        for (genvar n = 0; n < W; n++) begin : g_bit
            localparam int unsigned REGB = MIRROR ? (W - 1 - n) : n;
            localparam int unsigned BUSB = (BSWAP && NBYTES > 1)
                ? ((REGB % 8) + 8 * (NBYTES - 1 - REGB / 8)) : REGB;
            // route one line to its bus bit in each direction
            assign line_o[n]    = bus_i[BUSB];
            assign bus_o[BUSB]  = line_i[n];
        end
    endgenerate
endmodule

// File: rtl/mmgpio_regs.sv
// Output latch and direction mask with their write decode.
// Write data arrives already in line order. There is one write per strobe.
module mmgpio_regs
    import mmgpio_pkg::*;
#(
    parameter int unsigned W       = 32,
    parameter bit          HAS_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [W-1:0]     wr_lines,
    output logic [W-1:0]     latch_o,
    output logic [W-1:0]     dir_o
);
    logic [W-1:0] latch_q, dir_q, latch_d, dir_d;

    // next-state decode of a write
    always_comb begin
        latch_d = latch_q;
        dir_d   = dir_q;
        if (wr_en) begin
            case (wr_ofs)
                OFS_SET:  latch_d = HAS_CLR ? (latch_q | wr_lines) : wr_lines;
                OFS_CLR:  latch_d = HAS_CLR ? (latch_q & ~wr_lines) : latch_q;
                OFS_DOUT: dir_d   = wr_lines;
                OFS_DIN:  dir_d   = ~wr_lines;
                default:  ;
            endcase
        end
    end

    // hold the latch and the direction mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            dir_q   <= dir_d;
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;
endmodule

// File: rtl/mmgpio_readmux.sv
// Selects the line-order value of the addressed register for a read.
// Combinational. Write-only and unmapped offsets give zero.
module mmgpio_readmux
    import mmgpio_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [OFS_W-1:0] rd_ofs,
    input  logic [W-1:0]     pins,
    input  logic [W-1:0]     latch,
    input  logic [W-1:0]     dir,
    output logic [W-1:0]     rd_lines
);
    // choose the source register
    always_comb begin
        case (rd_ofs)
            OFS_DATA: rd_lines = pins;
            OFS_SET:  rd_lines = latch;
            OFS_DOUT: rd_lines = dir;
            OFS_DIN:  rd_lines = ~dir;
            default:  rd_lines = '0;
        endcase
    end
endmodule

// File: rtl/mmgpio_ctrl.sv
// Top of the GPIO register controller. It joins the lane maps, the
// register state, the read selection and the pad synchroniser.
// Assumes one access per strobe. Read data is registered.
module mmgpio_ctrl
    import mmgpio_pkg::*;
#(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned ADDR_W  = 3,
    parameter bit          MIRROR  = 1'b0,
    parameter bit          BSWAP   = 1'b0,
    parameter bit          HAS_CLR = 1'b1,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  pad_in,
    output logic [REG_W-1:0]  pad_out,
    output logic [REG_W-1:0]  pad_oe
);
    generate
        if (!(REG_W == 8 || REG_W == 16 || REG_W == 32 || REG_W == 64)) begin : g_bad_w
            $error("register width must be 8, 16, 32 or 64");
        end
        if (REG_W == 64 && BSWAP) begin : g_bad_swap
            $error("lane reversal is not offered at 64 bits");
        end
        if (ADDR_W < OFS_W) begin : g_bad_addr
            $error("address must hold at least three bits");
        end
    endgenerate

    logic [OFS_W-1:0] ofs;
    logic             high_zero;
    logic [REG_W-1:0] wr_lines, latch, dir, pins, rd_lines, rd_bus, rd_q;

    assign ofs = bus_addr[OFS_W-1:0];

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            assign high_zero = (bus_addr[ADDR_W-1:OFS_W] == '0);
        end else begin : g_nohi
            assign high_zero = 1'b1;
        end
    endgenerate

    mmgpio_lane_map #(.W(REG_W), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_map (
        .bus_i (bus_wdata),
        .line_o(wr_lines),
        .line_i(rd_lines),
        .bus_o (rd_bus)
    );

    mmgpio_regs #(.W(REG_W), .HAS_CLR(HAS_CLR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_sel && bus_we && high_zero),
        .wr_ofs  (ofs),
        .wr_lines(wr_lines),
        .latch_o (latch),
        .dir_o   (dir)
    );

    mmgpio_sync #(.W(REG_W), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pad_in),
        .sync_o (pins)
    );

    mmgpio_readmux #(.W(REG_W)) u_rmux (
        .rd_ofs  (high_zero ? ofs : OFS_W'(7)),
        .pins    (pins),
        .latch   (latch),
        .dir     (dir),
        .rd_lines(rd_lines)
    );

    // capture read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else if (bus_sel && !bus_we) rd_q <= rd_bus;
    end

    assign bus_rdata = rd_q;
    assign pad_out   = latch;
    assign pad_oe    = dir;
endmodule

// File: rtl/mmgpio_ctrl_chk.sv
// Checker bound to the GPIO controller. It watches the bus, the pads
// and the read data over time.
module mmgpio_ctrl_chk #(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned ADDR_W  = 3,
    parameter bit          HAS_CLR = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [REG_W-1:0]  pad_out,
    input logic [REG_W-1:0]  pad_oe
);
    logic wr, rd;
    assign wr = bus_sel && bus_we;
    assign rd = bus_sel && !bus_we;

    // R1: reset clears latch and direction
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0));

    // R2: unmapped and clear offsets read zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (bus_addr > ADDR_W'(4) || bus_addr == ADDR_W'(2))) |=> bus_rdata == '0);

    // R3: a set write only raises lines
    a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CLR && wr && bus_addr == ADDR_W'(1)) |=> ((pad_out & $past(pad_out)) == $past(pad_out)));

    // R4: a clear write only lowers lines
    a_r4_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(2)) |=> ((pad_out & ~$past(pad_out)) == '0));

    // R6: the direction mask changes only on a direction write
    a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(4))) |=> $stable(pad_oe));

    // R8: writes to the data offset touch nothing
    a_r8_data_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(0)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind mmgpio_ctrl mmgpio_ctrl_chk #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .HAS_CLR(HAS_CLR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/mmgpio_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench. Instance A: 32 bits, plain map, clear register present.
// Instance B: 16 bits, mirrored, lanes reversed, no clear register.
module mmgpio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_a, out_a, oe_a, ext_a = '0, pin_a;
    logic [15:0] rd_b, out_b, oe_b, ext_b = '0, pin_b;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign pin_a = (oe_a & out_a) | (~oe_a & ext_a);
    assign pin_b = (oe_b & out_b) | (~oe_b & ext_b);

    mmgpio_ctrl u_mmgpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_a), .pad_in(pin_a), .pad_out(out_a), .pad_oe(oe_a)
    );

    mmgpio_ctrl #(.REG_W(16), .MIRROR(1'b1), .BSWAP(1'b1), .HAS_CLR(1'b0)) u_alt (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata[15:0]), .bus_rdata(rd_b), .pad_in(pin_b), .pad_out(out_b), .pad_oe(oe_b)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_a = !b; sel_b = b; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_a = !b; sel_b = b; we = 1'b0; addr = a;
        @(posedge clk);
        #1 d = b ? {16'h0, rd_b} : rd_a;
        sel_a = 1'b0; sel_b = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 oe", oe_a, 32'h0);
        check("R1 out", out_a, 32'h0);
        rd(0, 3'd3, v); check("R1 dirout", v, 32'h0);
        rd(0, 3'd4, v); check("R7 dirin after reset", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(0, 3'd1, 32'h0000_00F0); #1 check("R3 set", out_a, 32'h0000_00F0);
        wr(0, 3'd1, 32'h0000_0F00); #1 check("R3 set keeps", out_a, 32'h0000_0FF0);
        rd(0, 3'd1, v); check("R3 readback", v, 32'h0000_0FF0);
        wr(0, 3'd2, 32'h0000_0030); #1 check("R4 clear", out_a, 32'h0000_0FC0);
        wr(0, 3'd2, 32'h0); #1 check("R4 zero clear", out_a, 32'h0000_0FC0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(0, 3'd3, 32'h0000_FFFF); #1 check("R6 oe", oe_a, 32'h0000_FFFF);
        rd(0, 3'd3, v); check("R6 readback", v, 32'h0000_FFFF);
        rd(0, 3'd4, v); check("R7 complement", v, 32'hFFFF_0000);
        wr(0, 3'd4, 32'h0000_000F); #1 check("R7 write", oe_a, 32'hFFFF_FFF0);
    endtask

    task automatic t_data();
        logic [31:0] v;
        wr(0, 3'd3, 32'h0);
        repeat (4) @(negedge clk);
        rd(0, 3'd0, v); check("R8 idle pins", v, 32'h0);
        @(negedge clk); ext_a = 32'h1234_5678;
        rd(0, 3'd0, v); check("R8 latency early", v, 32'h0);
        repeat (3) @(negedge clk);
        rd(0, 3'd0, v); check("R8 pins", v, 32'h1234_5678);
        wr(0, 3'd0, 32'hFFFF_FFFF); #1 check("R8 data write out", out_a, 32'h0000_0FC0);
        check("R8 data write oe", oe_a, 32'h0);
        wr(0, 3'd3, 32'h0000_FFFF);
        repeat (4) @(negedge clk);
        rd(0, 3'd0, v); check("R11 output readback", v, 32'h1234_0FC0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(0, 3'd2, v); check("R2 clear reads zero", v, 32'h0);
        rd(0, 3'd5, v); check("R2 offset 5", v, 32'h0);
        rd(0, 3'd7, v); check("R2 offset 7", v, 32'h0);
        wr(0, 3'd6, 32'hFFFF_FFFF); #1 check("R2 unmapped write out", out_a, 32'h0000_0FC0);
        check("R2 unmapped write oe", oe_a, 32'h0000_FFFF);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        wr(1, 3'd1, 32'h0080); #1 check("R9 R10 line0", {16'h0, out_b}, 32'h0001);
        rd(1, 3'd1, v); check("R10 readback", v, 32'h0080);
        wr(1, 3'd1, 32'h0100); #1 check("R5 load whole", {16'h0, out_b}, 32'h8000);
        wr(1, 3'd2, 32'hFFFF); #1 check("R5 clear ignored", {16'h0, out_b}, 32'h8000);
        wr(1, 3'd3, 32'h0001); #1 check("R9 R10 dir map", {16'h0, oe_b}, 32'h0080);
        rd(1, 3'd4, v); check("R7 alt complement", v, 32'hFFFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_dir();
        t_data();
        t_unmapped();
        t_alt();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule